// File: doc/BRIEF.md
# Lane-Interleaved Byte Memory

This block is a synchronous memory that software and neighbouring logic see as 512 bytes behind a 9-bit address, while the storage underneath is 256 physical words of 16 bits. Each byte lives in one of the two bit lanes of a physical word. The even lane uses bit positions 0, 2, 4 and so on. The odd lane uses bit positions 1, 3, 5 and so on. The low eight address bits pick the physical word. The top address bit picks the lane. Two logical addresses that differ only in that top bit therefore share one physical word.

There is one write port and one read port, both on a single clock. A write touches only the eight bits of its own lane, so the partner byte in the same word keeps its value. A read is registered: the byte appears one cycle after the address is sampled, and the read register holds its value whenever the read is not enabled. At reset the whole physical array is loaded from a 4096-bit image parameter. The image is arranged as 16 groups of 256 bits, and each group holds 16 consecutive physical words with the least significant word first.

Top module: `lane_byte_ram`

## Requirements
- R1: During any clock edge with `rst_n` low, `rd_data` becomes 0 and physical word w is loaded from `INIT_IMAGE[16*w +: 16]`. That span is word w%16 of group w/16, groups counting from the least significant end.
- R2: A read of address a returns bit i of the byte as bit 2*i + a[8] of physical word a[7:0].
- R3: When `rd_en` and `rd_clk_en` are both 1 at a rising edge, `rd_data` shows the byte at `rd_addr` right after that edge.
- R4: When `rd_en` or `rd_clk_en` is 0 at an edge, `rd_data` keeps its previous value.
- R5: When `wr_en` and `wr_clk_en` are both 1 at an edge, the byte at `wr_addr` takes `wr_data`, and a read issued on the next edge returns it.
- R6: A write with `wr_en` or `wr_clk_en` at 0 leaves the memory unchanged.
- R7: A write to address a leaves the byte at address a XOR 256 unchanged, although both bytes share one physical word.
- R8: When a read and a write target the same address on the same edge, the read returns the data held before that write.
- R9: All 512 addresses hold independent bytes: after every address is written with a distinct pattern, each one reads back its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset; loads the image and clears the read register |
| wr_clk_en | input | 1 | Write-side clock enable |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Logical write address |
| wr_data | input | 8 | Byte to write |
| rd_clk_en | input | 1 | Read-side clock enable |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 9 | Logical read address |
| rd_data | output | 8 | Registered read byte |

## Verification
The hardest case to reach is damage to a partner lane. It only shows when the byte that shares a physical word with a freshly written byte holds a known value that differs from the write data. The bench covers this in two ways. First, it overrides the image with a computed pattern, so both lanes of every word start out distinct and nonzero. Second, it alternates writes to address a and address a XOR 256 with reads of the opposite partner. The read-before-write case is driven by enabling both ports on the same address in one cycle, then reading again on the next cycle to see the new byte.

// File: rtl/lane_ram_pkg.sv
package lane_ram_pkg;
    localparam int BYTE_W      = 8;
    localparam int LOG_AW      = 9;
    localparam int PHYS_AW     = LOG_AW - 1;
    localparam int PHYS_W      = 2 * BYTE_W;
    localparam int WORDS       = 1 << PHYS_AW;
    localparam int GROUP_WORDS = 16;
    localparam int GROUPS      = WORDS / GROUP_WORDS;
    localparam int GROUP_BITS  = GROUP_WORDS * PHYS_W;
    localparam int INIT_W      = GROUPS * GROUP_BITS;

    typedef logic [LOG_AW-1:0]  laddr_t;
    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [PHYS_W-1:0]  pword_t;
    typedef logic [PHYS_AW-1:0] pidx_t;

    typedef struct packed {
        pidx_t idx;
        logic  odd;
    } loc_t;

    typedef struct packed {
        logic   en;
        pidx_t  idx;
        pword_t data;
        pword_t mask;
    } wr_req_t;

    typedef struct packed {
        byte_t rd_data;
    } rd_state_t;
endpackage

// File: rtl/lane_addr_map.sv
module lane_addr_map
    import lane_ram_pkg::*;
(
    input  laddr_t addr,
    output loc_t   loc
);
    always_comb begin
        loc.idx = addr[PHYS_AW-1:0];
        loc.odd = addr[LOG_AW-1];
    end
endmodule

// File: rtl/lane_spread.sv
module lane_spread
    import lane_ram_pkg::*;
(
    input  byte_t  data,
    input  logic   odd,
    output pword_t bits,
    output pword_t mask
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_lane
        assign bits[2*i]     = data[i];
        assign bits[2*i+1]   = data[i];
        assign mask[2*i]     = ~odd;
        assign mask[2*i+1]   = odd;
    end
endmodule

// File: rtl/lane_gather.sv
module lane_gather
    import lane_ram_pkg::*;
(
    input  pword_t word,
    input  logic   odd,
    output byte_t  data
);
    for (genvar i = 0; i < BYTE_W; i++) begin : g_pick
        assign data[i] = odd ? word[2*i+1] : word[2*i];
    end
endmodule

// File: rtl/lane_word_store.sv
module lane_word_store
    import lane_ram_pkg::*;
#(
    parameter logic [INIT_W-1:0] INIT_IMAGE = '0
) (
    input  logic    clk,
    input  logic    rst_n,
    input  wr_req_t wr_req,
    input  pidx_t   rd_idx,
    output pword_t  rd_word
);
    pword_t mem_q [WORDS];
    pword_t merged_d;

    // Lane merge: keep bits outside the mask, replace bits inside it.
    always_comb begin
        merged_d = (mem_q[wr_req.idx] & ~wr_req.mask)
                 | (wr_req.data & wr_req.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) begin
                mem_q[w] <= INIT_IMAGE[w*PHYS_W +: PHYS_W];
            end
        end else if (wr_req.en) begin
            mem_q[wr_req.idx] <= merged_d;
        end
    end

    assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/lane_byte_ram.sv
module lane_byte_ram
    import lane_ram_pkg::*;
#(
    parameter logic [INIT_W-1:0] INIT_IMAGE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_clk_en,
    input  logic                wr_en,
    input  logic [LOG_AW-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_clk_en,
    input  logic                rd_en,
    input  logic [LOG_AW-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data
);
    loc_t      wr_loc;
    loc_t      rd_loc;
    pword_t    spread_bits;
    pword_t    spread_mask;
    pword_t    rd_word;
    byte_t     rd_byte;
    wr_req_t   wr_req;
    rd_state_t st_d;
    rd_state_t st_q;

    lane_addr_map i_wr_map (.addr(wr_addr), .loc(wr_loc));
    lane_addr_map i_rd_map (.addr(rd_addr), .loc(rd_loc));

    lane_spread i_spread (
        .data (wr_data),
        .odd  (wr_loc.odd),
        .bits (spread_bits),
        .mask (spread_mask)
    );

    lane_word_store #(.INIT_IMAGE(INIT_IMAGE)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_req),
        .rd_idx  (rd_loc.idx),
        .rd_word (rd_word)
    );

    lane_gather i_gather (
        .word (rd_word),
        .odd  (rd_loc.odd),
        .data (rd_byte)
    );

    always_comb begin
        wr_req.en   = wr_en && wr_clk_en;
        wr_req.idx  = wr_loc.idx;
        wr_req.data = spread_bits;
        wr_req.mask = spread_mask;
        st_d = st_q;
        if (rd_en && rd_clk_en) begin
            st_d.rd_data = rd_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.rd_data;
endmodule

// File: rtl/lane_byte_ram_chk.sv
module lane_byte_ram_chk
    import lane_ram_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_clk_en,
    input logic              wr_en,
    input logic [LOG_AW-1:0] wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              rd_clk_en,
    input logic              rd_en,
    input logic [LOG_AW-1:0] rd_addr,
    input logic [BYTE_W-1:0] rd_data
);
    logic   rd_fire;
    logic   wr_fire;
    logic   wr_v_q;
    laddr_t wa_q;
    byte_t  wd_q;
    logic   rd_v_q;
    laddr_t ra_q;
    logic   hit_q;

    assign rd_fire = rd_en && rd_clk_en;
    assign wr_fire = wr_en && wr_clk_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_v_q <= 1'b0;
            wa_q   <= '0;
            wd_q   <= '0;
            rd_v_q <= 1'b0;
            ra_q   <= '0;
            hit_q  <= 1'b0;
        end else begin
            wr_v_q <= wr_fire;
            wa_q   <= wr_addr;
            wd_q   <= wr_data;
            rd_v_q <= rd_fire;
            ra_q   <= rd_addr;
            hit_q  <= wr_fire && (wr_addr == rd_addr);
        end
    end

    p_rst_zero_r1: assert property (@(posedge clk)
        !rst_n |=> rd_data == '0);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rd_data));

    p_wr_then_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_v_q && rd_fire && rd_addr == wa_q) |=> rd_data == $past(wd_q));

    p_reread_same_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_v_q && !hit_q && rd_fire && rd_addr == ra_q)
        |=> rd_data == $past(rd_data));
endmodule

bind lane_byte_ram lane_byte_ram_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_clk_en (wr_clk_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_clk_en (rd_clk_en),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/test_lane_byte_ram.sv
module test_lane_byte_ram;
    import lane_ram_pkg::*;

    function automatic logic [INIT_W-1:0] make_img();
        logic [INIT_W-1:0] img;
        logic [15:0] v;
        img = '0;
        for (int w = 0; w < WORDS; w++) begin
            v = 16'((w * 16'h9E37) ^ 16'h5AC3);
            img[w*16 +: 16] = v;
        end
        return img;
    endfunction

    localparam logic [INIT_W-1:0] IMG = make_img();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_clk_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_clk_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    byte_t model [512];

    always #2 clk = ~clk;

    lane_byte_ram #(.INIT_IMAGE(IMG)) i_lane_byte_ram (
        .clk(clk), .rst_n(rst_n),
        .wr_clk_en(wr_clk_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk_en(rd_clk_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_clk_en = 0; rd_en = 0; rd_clk_en = 0;
    endtask

    // R2: byte bit i at physical bit 2*i + a[8] of word a[7:0]; word w at IMG[16w +: 16]
    task automatic build_model();
        for (int a = 0; a < 512; a++) begin
            for (int i = 0; i < 8; i++) begin
                model[a][i] = IMG[(a % 256) * 16 + 2 * i + (a / 256)];
            end
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        wr_addr = 9'(a); wr_data = d; wr_en = 1; wr_clk_en = 1;
        @(negedge clk);
        idle();
        model[a] = d;
    endtask

    task automatic rd_chk(input int a, input string req);
        rd_addr = 9'(a); rd_en = 1; rd_clk_en = 1;
        @(negedge clk);
        idle();
        chk(rd_data, model[a], req, $sformatf("read addr %0d", a));
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        chk(rd_data, 8'h00, "R1", "rd_data after reset");
        rst_n = 1;
        @(negedge clk);
        chk(rd_data, 8'h00, "R1", "rd_data idle after reset");
    endtask

    task automatic t_image();
        rd_chk(0,   "R1");
        rd_chk(1,   "R2");
        rd_chk(255, "R2");
        rd_chk(256, "R2");
        rd_chk(257, "R2");
        rd_chk(16,  "R1");
        rd_chk(272, "R1");
        rd_chk(511, "R3");
    endtask

    task automatic t_write_read();
        wr(3, 8'hA7);   rd_chk(3,   "R5");
        wr(300, 8'h1E); rd_chk(300, "R5");
        wr(128, 8'h00); rd_chk(128, "R5");
    endtask

    task automatic t_lane_isolation();
        wr(5, 8'hF0);
        rd_chk(261, "R7");
        wr(261, 8'h0F);
        rd_chk(5, "R7");
        rd_chk(261, "R7");
    endtask

    task automatic t_gated_write();
        wr_addr = 9'd30; wr_data = ~model[30]; wr_en = 1; wr_clk_en = 0;
        @(negedge clk);
        wr_en = 0; wr_clk_en = 1;
        @(negedge clk);
        idle();
        rd_chk(30, "R6");
    endtask

    task automatic t_hold();
        wr(10, 8'h3C);
        wr(11, 8'hC3);
        rd_chk(10, "R3");
        rd_addr = 9'd11; rd_en = 0; rd_clk_en = 1;
        @(negedge clk);
        chk(rd_data, 8'h3C, "R4", "hold with rd_en low");
        rd_en = 1; rd_clk_en = 0;
        @(negedge clk);
        chk(rd_data, 8'h3C, "R4", "hold with rd_clk_en low");
        idle();
    endtask

    task automatic t_read_before_write();
        wr(20, 8'h11);
        wr_addr = 9'd20; wr_data = 8'h99; wr_en = 1; wr_clk_en = 1;
        rd_addr = 9'd20; rd_en = 1; rd_clk_en = 1;
        @(negedge clk);
        idle();
        chk(rd_data, 8'h11, "R8", "same-cycle read returns old byte");
        model[20] = 8'h99;
        rd_chk(20, "R8");
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 512; a++) begin
            wr(a, 8'(a) ^ {a[8], 7'h5A});
        end
        for (int a = 0; a < 512; a++) begin
            rd_chk(a, "R9");
        end
    endtask

    initial begin
        build_model();
        t_reset();
        t_image();
        t_write_read();
        t_lane_isolation();
        t_gated_write();
        t_hold();
        t_read_before_write();
        t_sweep();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule